// File: doc/BRIEF.md
# Control Endpoint Transaction Controller

This block runs the default control endpoint of a USB device at the transaction level. A packet decoder in front of it reports each token: its kind, the length of the data packet that came with it, whether that packet was DATA1, and, for a setup packet, the direction bit and the requested length. The block decides whether each token gets ACK, NAK or STALL, or no handshake at all, and it tracks the endpoint through three states: idle (setup and status handling), transmit data stage and receive data stage.

Firmware drives the block with single-cycle strobes. It releases a received packet, marks the last packet of a data stage, loads a transmit packet, requests a stall, and clears the stall-sent flag, the premature-end flag and the interrupt flag. The block tells protocol errors (answered with STALL) apart from a transfer that ends early (reported on a separate premature-end flag). It sets one endpoint interrupt flag for every event that firmware must handle, and drives an interrupt request when both the endpoint mask and the global enable are set.

Top module: `ctrl_endpoint`

## Requirements
- R1: While `rst_n` is low, and on the clock edge after `busReset` is high, the block is in idle (`epState` 0; transmit is 1, receive is 2), every status flag and the interrupt flag are 0, and no handshake is issued.
- R2: A token is a one-cycle `tokValid` pulse with `tokKind` 0 setup, 1 IN, 2 OUT; kind 3 is ignored. A handshake appears on the edge after the token, for one cycle, as `hsValid` with `hsCode` 1 ACK, 2 NAK, 3 STALL. A setup token whose `dataLen` is 8 is answered with ACK and sets packet-ready and the interrupt flag. A setup token of any other length gets no handshake and changes no flag.
- R3: While packet-ready is set, a further setup packet of length 8, or an OUT data packet in the receive stage, is answered with NAK and changes no flag.
- R4: With packet-ready set by a setup whose requested length is nonzero, a cycle with `fwClrPktRdy` and no `fwDataEnd` moves idle to transmit when the direction bit was 1 and to receive when it was 0. `fwClrPktRdy` together with `fwDataEnd` keeps the endpoint in idle with data-end set.
- R5: In transmit, an IN token is answered with ACK when firmware has loaded a packet with `fwTxReady`; this consumes the packet and sets the interrupt flag. With no packet loaded and data-end clear, the IN token is answered with NAK.
- R6: In transmit with data-end set and no packet loaded, an IN token is answered with STALL, sets stall-sent and the interrupt flag, clears data-end and returns to idle.
- R7: In receive, an OUT token is answered with STALL, with the same effects as in R6, when data-end is set or when `dataLen` exceeds `MAX_PKT` (64 by default). Otherwise, with packet-ready clear, it is answered with ACK and sets packet-ready and the interrupt flag.
- R8: The status stage is answered with ACK, clears data-end, sets the interrupt flag and leaves the endpoint in idle. It is an IN token in receive with data-end set, or in idle with data-end set, or an OUT in transmit with data-end set and no packet loaded that is DATA1 of length 0. Such an OUT with a nonzero length, or marked DATA0, is answered with STALL.
- R9: Two tokens end a data stage early: an OUT in transmit (outside the status case of R8) and an IN in receive without data-end. Either gets no handshake, sets setup-end and the interrupt flag and returns to idle. A length-8 setup in either data stage sets setup-end, returns to idle and is then answered as in R2 and R3. `fwClrSetupEnd` clears setup-end.
- R10: After `fwSendStall`, the next token of kind 0 to 2 is answered with STALL, whatever the state, and returns the endpoint to idle. This sets stall-sent and the interrupt flag and clears the stall request. Stall-sent stays set until `fwClrSentStall`.
- R11: The interrupt flag is set by every ACK, every STALL and every setup-end event, independently of the mask. It is cleared by `fwClrInt`. `intReq` is high exactly while the flag, `intMask` and `usbIntEn` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busReset | input | 1 | USB bus reset seen on the line; synchronous clear |
| tokValid | input | 1 | One-cycle token event |
| tokKind | input | 2 | 0 setup, 1 IN, 2 OUT, 3 ignored |
| dataLen | input | LEN_W | Byte length of the data packet attached to the token |
| dataPid1 | input | 1 | Data packet carried DATA1 |
| setupDirIn | input | 1 | Direction bit of the setup packet (1 = device to host) |
| setupLength | input | 16 | Requested transfer length field of the setup packet |
| fwClrPktRdy | input | 1 | Firmware releases the received packet |
| fwDataEnd | input | 1 | Firmware marks the last packet of the data stage |
| fwTxReady | input | 1 | Firmware has loaded a transmit packet |
| fwSendStall | input | 1 | Firmware requests a stall |
| fwClrSentStall | input | 1 | Clears stall-sent |
| fwClrSetupEnd | input | 1 | Clears setup-end |
| fwClrInt | input | 1 | Clears the interrupt flag |
| intMask | input | 1 | Endpoint interrupt mask |
| usbIntEn | input | 1 | Global USB interrupt enable |
| hsValid | output | 1 | Handshake issued this cycle |
| hsCode | output | 2 | 1 ACK, 2 NAK, 3 STALL, 0 none |
| epState | output | 2 | 0 idle, 1 transmit, 2 receive |
| pktRdy | output | 1 | Packet-ready flag |
| dataEnd | output | 1 | Data-end flag |
| sendStallPend | output | 1 | Stall requested and not yet sent |
| sentStall | output | 1 | Stall-sent flag |
| setupEnd | output | 1 | Premature end of a control transfer |
| epIntFlag | output | 1 | Endpoint interrupt flag |
| intReq | output | 1 | Interrupt request |

## Verification
The bench walks complete control transfers of each shape: no data stage, a transmit stage of several packets, and a receive stage released packet by packet. Running these shapes one after another shows that the status-stage rules differ by direction and that a transfer leaves no stale data-end behind. Each of the error paths is then forced separately: a short setup, an oversized OUT, and an extra IN or OUT after data-end. These tell the silent reject apart from the STALL reply. A token that breaks off a data stage, and a setup that interrupts one, separate the premature-end flag from the stall flag. Firmware stall requests in several states, interrupt mask combinations and a bus reset mid-transfer complete the set.

// File: rtl/ctrl_ep_pkg.sv
package ctrl_ep_pkg;

  localparam int SETUP_BYTES = 8;
  localparam int REQ_LEN_W   = 16;

  typedef enum logic [1:0] {
    EP_IDLE = 2'd0,
    EP_TX   = 2'd1,
    EP_RX   = 2'd2
  } epState_e;

  localparam logic [1:0] TOK_SETUP = 2'd0;
  localparam logic [1:0] TOK_IN    = 2'd1;
  localparam logic [1:0] TOK_OUT   = 2'd2;
  localparam logic [1:0] TOK_RSVD  = 2'd3;

  localparam logic [1:0] HS_NONE  = 2'd0;
  localparam logic [1:0] HS_ACK   = 2'd1;
  localparam logic [1:0] HS_NAK   = 2'd2;
  localparam logic [1:0] HS_STALL = 2'd3;

  // strobes from the control FSM to the flag datapath
  typedef struct packed {
    logic [1:0] hsCode;
    logic       setPktRdy;
    logic       clrDataEnd;
    logic       clrSendStall;
    logic       setSentStall;
    logic       setSetupEnd;
    logic       clrTxLoaded;
    logic       raiseInt;
    logic       latchSetup;
  } epStrobe_t;

  // flag state the control FSM decides on
  typedef struct packed {
    logic pktRdy;
    logic dataEnd;
    logic sendStall;
    logic txLoaded;
    logic setupDirIn;
    logic setupHasData;
  } epFlags_t;

endpackage

// File: rtl/ctrl_ep_control.sv
module ctrl_ep_control
  import ctrl_ep_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int LEN_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busReset,
  input  logic             tokValid,
  input  logic [1:0]       tokKind,
  input  logic [LEN_W-1:0] dataLen,
  input  logic             dataPid1,
  input  logic             fwClrPktRdy,
  input  logic             fwDataEnd,
  input  epFlags_t         flags,
  output epStrobe_t        stb,
  output logic [1:0]       epState
);

  epState_e stateQ, stateD;
  logic tokLive, setupLenOk, tooLong, statusPktOk;

  assign tokLive     = tokValid && (tokKind != TOK_RSVD);
  assign setupLenOk  = (dataLen == LEN_W'(SETUP_BYTES));
  assign tooLong     = (dataLen > LEN_W'(MAX_PKT));
  assign statusPktOk = dataPid1 && (dataLen == '0);

  function automatic epStrobe_t withStall(epStrobe_t s);
    epStrobe_t r = s;
    r.hsCode       = HS_STALL;
    r.setSentStall = 1'b1;
    r.raiseInt     = 1'b1;
    r.clrDataEnd   = 1'b1;
    r.clrTxLoaded  = 1'b1;
    return r;
  endfunction

  function automatic epStrobe_t withAbort(epStrobe_t s);
    epStrobe_t r = s;
    r.setSetupEnd = 1'b1;
    r.raiseInt    = 1'b1;
    r.clrDataEnd  = 1'b1;
    r.clrTxLoaded = 1'b1;
    return r;
  endfunction

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    if (tokLive && flags.sendStall) begin
      stb = withStall(stb);
      stb.clrSendStall = 1'b1;
      stateD = EP_IDLE;
    end else if (tokLive) begin
      case (tokKind)
        TOK_SETUP: begin
          if (setupLenOk) begin
            if (stateQ != EP_IDLE) begin
              stb = withAbort(stb);
              stateD = EP_IDLE;
            end
            if (flags.pktRdy) begin
              stb.hsCode = HS_NAK;
            end else begin
              stb.hsCode     = HS_ACK;
              stb.setPktRdy  = 1'b1;
              stb.raiseInt   = 1'b1;
              stb.clrDataEnd = 1'b1;
              stb.latchSetup = 1'b1;
            end
          end
        end
        TOK_IN: begin
          case (stateQ)
            EP_TX: begin
              if (flags.txLoaded) begin
                stb.hsCode      = HS_ACK;
                stb.clrTxLoaded = 1'b1;
                stb.raiseInt    = 1'b1;
              end else if (flags.dataEnd) begin
                stb = withStall(stb);
                stateD = EP_IDLE;
              end else begin
                stb.hsCode = HS_NAK;
              end
            end
            EP_RX: begin
              if (flags.dataEnd) begin
                stb.hsCode     = HS_ACK;
                stb.clrDataEnd = 1'b1;
                stb.raiseInt   = 1'b1;
              end else begin
                stb = withAbort(stb);
              end
              stateD = EP_IDLE;
            end
            default: begin
              if (flags.dataEnd) begin
                stb.hsCode     = HS_ACK;
                stb.clrDataEnd = 1'b1;
                stb.raiseInt   = 1'b1;
              end else begin
                stb.hsCode = HS_NAK;
              end
            end
          endcase
        end
        default: begin // OUT
          case (stateQ)
            EP_TX: begin
              if (flags.dataEnd && !flags.txLoaded) begin
                if (statusPktOk) begin
                  stb.hsCode     = HS_ACK;
                  stb.clrDataEnd = 1'b1;
                  stb.raiseInt   = 1'b1;
                end else begin
                  stb = withStall(stb);
                end
              end else begin
                stb = withAbort(stb);
              end
              stateD = EP_IDLE;
            end
            EP_RX: begin
              if (flags.dataEnd || tooLong) begin
                stb = withStall(stb);
                stateD = EP_IDLE;
              end else if (flags.pktRdy) begin
                stb.hsCode = HS_NAK;
              end else begin
                stb.hsCode    = HS_ACK;
                stb.setPktRdy = 1'b1;
                stb.raiseInt  = 1'b1;
              end
            end
            default: stb.hsCode = HS_NAK;
          endcase
        end
      endcase
    end else if (fwClrPktRdy && !fwDataEnd && (stateQ == EP_IDLE)
                 && flags.pktRdy && flags.setupHasData) begin
      stateD = flags.setupDirIn ? EP_TX : EP_RX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stateQ <= EP_IDLE;
    else if (busReset) stateQ <= EP_IDLE;
    else               stateQ <= stateD;
  end

  assign epState = stateQ;

endmodule

// File: rtl/ctrl_ep_datapath.sv
module ctrl_ep_datapath
  import ctrl_ep_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busReset,
  input  epStrobe_t            stb,
  input  logic                 fwClrPktRdy,
  input  logic                 fwDataEnd,
  input  logic                 fwTxReady,
  input  logic                 fwSendStall,
  input  logic                 fwClrSentStall,
  input  logic                 fwClrSetupEnd,
  input  logic                 fwClrInt,
  input  logic                 setupDirIn,
  input  logic [REQ_LEN_W-1:0] setupLength,
  input  logic                 intMask,
  input  logic                 usbIntEn,
  output epFlags_t             flags,
  output logic                 hsValid,
  output logic [1:0]           hsCode,
  output logic                 sentStall,
  output logic                 setupEnd,
  output logic                 epIntFlag,
  output logic                 intReq
);

  // token-driven strobes take precedence over firmware writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags     <= '0;
      hsValid   <= 1'b0;
      hsCode    <= HS_NONE;
      sentStall <= 1'b0;
      setupEnd  <= 1'b0;
      epIntFlag <= 1'b0;
    end else if (busReset) begin
      flags     <= '0;
      hsValid   <= 1'b0;
      hsCode    <= HS_NONE;
      sentStall <= 1'b0;
      setupEnd  <= 1'b0;
      epIntFlag <= 1'b0;
    end else begin
      hsValid <= (stb.hsCode != HS_NONE);
      hsCode  <= stb.hsCode;

      if (stb.setPktRdy)     flags.pktRdy <= 1'b1;
      else if (fwClrPktRdy)  flags.pktRdy <= 1'b0;

      if (stb.clrDataEnd)    flags.dataEnd <= 1'b0;
      else if (fwDataEnd)    flags.dataEnd <= 1'b1;

      if (stb.clrSendStall)  flags.sendStall <= 1'b0;
      else if (fwSendStall)  flags.sendStall <= 1'b1;

      if (stb.clrTxLoaded)   flags.txLoaded <= 1'b0;
      else if (fwTxReady)    flags.txLoaded <= 1'b1;

      if (stb.latchSetup) begin
        flags.setupDirIn   <= setupDirIn;
        flags.setupHasData <= (setupLength != '0);
      end

      if (stb.setSentStall)  sentStall <= 1'b1;
      else if (fwClrSentStall) sentStall <= 1'b0;

      if (stb.setSetupEnd)   setupEnd <= 1'b1;
      else if (fwClrSetupEnd) setupEnd <= 1'b0;

      if (stb.raiseInt)      epIntFlag <= 1'b1;
      else if (fwClrInt)     epIntFlag <= 1'b0;
    end
  end

  assign intReq = epIntFlag & intMask & usbIntEn;

endmodule

// File: rtl/ctrl_endpoint.sv
module ctrl_endpoint
  import ctrl_ep_pkg::*;
#(
  parameter int  MAX_PKT = 64,
  localparam int LEN_W   = $clog2(2 * MAX_PKT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busReset,
  input  logic                 tokValid,
  input  logic [1:0]           tokKind,
  input  logic [LEN_W-1:0]     dataLen,
  input  logic                 dataPid1,
  input  logic                 setupDirIn,
  input  logic [REQ_LEN_W-1:0] setupLength,
  input  logic                 fwClrPktRdy,
  input  logic                 fwDataEnd,
  input  logic                 fwTxReady,
  input  logic                 fwSendStall,
  input  logic                 fwClrSentStall,
  input  logic                 fwClrSetupEnd,
  input  logic                 fwClrInt,
  input  logic                 intMask,
  input  logic                 usbIntEn,
  output logic                 hsValid,
  output logic [1:0]           hsCode,
  output logic [1:0]           epState,
  output logic                 pktRdy,
  output logic                 dataEnd,
  output logic                 sendStallPend,
  output logic                 sentStall,
  output logic                 setupEnd,
  output logic                 epIntFlag,
  output logic                 intReq
);

  epStrobe_t stb;
  epFlags_t  flags;

  ctrl_ep_control #(.MAX_PKT(MAX_PKT), .LEN_W(LEN_W)) uCtrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .busReset    (busReset),
    .tokValid    (tokValid),
    .tokKind     (tokKind),
    .dataLen     (dataLen),
    .dataPid1    (dataPid1),
    .fwClrPktRdy (fwClrPktRdy),
    .fwDataEnd   (fwDataEnd),
    .flags       (flags),
    .stb         (stb),
    .epState     (epState)
  );

  ctrl_ep_datapath uPath (
    .clk            (clk),
    .rst_n          (rst_n),
    .busReset       (busReset),
    .stb            (stb),
    .fwClrPktRdy    (fwClrPktRdy),
    .fwDataEnd      (fwDataEnd),
    .fwTxReady      (fwTxReady),
    .fwSendStall    (fwSendStall),
    .fwClrSentStall (fwClrSentStall),
    .fwClrSetupEnd  (fwClrSetupEnd),
    .fwClrInt       (fwClrInt),
    .setupDirIn     (setupDirIn),
    .setupLength    (setupLength),
    .intMask        (intMask),
    .usbIntEn       (usbIntEn),
    .flags          (flags),
    .hsValid        (hsValid),
    .hsCode         (hsCode),
    .sentStall      (sentStall),
    .setupEnd       (setupEnd),
    .epIntFlag      (epIntFlag),
    .intReq         (intReq)
  );

  assign pktRdy        = flags.pktRdy;
  assign dataEnd       = flags.dataEnd;
  assign sendStallPend = flags.sendStall;

endmodule

// File: rtl/ctrl_endpoint_chk.sv
module ctrl_endpoint_chk #(
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busReset,
  input logic             tokValid,
  input logic [1:0]       tokKind,
  input logic [LEN_W-1:0] dataLen,
  input logic             hsValid,
  input logic [1:0]       hsCode,
  input logic [1:0]       epState,
  input logic             pktRdy,
  input logic             dataEnd,
  input logic             sendStallPend,
  input logic             sentStall,
  input logic             setupEnd,
  input logic             epIntFlag
);

  AST_BUS_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busReset |=> (epState == 2'd0) && !pktRdy && !dataEnd && !sentStall
                 && !setupEnd && !epIntFlag && !hsValid); // R1

  AST_SHORT_SETUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    tokValid && (tokKind == 2'd0) && (dataLen != LEN_W'(8)) && !sendStallPend
    && !busReset |=> !hsValid); // R2

  AST_SETUP_NAK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tokValid && (tokKind == 2'd0) && (dataLen == LEN_W'(8)) && pktRdy
    && !sendStallPend && !busReset |=> hsValid && (hsCode == 2'd2)); // R3

  AST_SETUP_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(setupEnd) |-> (epState == 2'd0)); // R9

  AST_STALL_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    tokValid && (tokKind != 2'd3) && sendStallPend && !busReset
    |=> hsValid && (hsCode == 2'd3) && sentStall && !sendStallPend
        && (epState == 2'd0)); // R10

  AST_ACK_RAISES_INT: assert property (@(posedge clk) disable iff (!rst_n)
    hsValid && (hsCode == 2'd1) |-> epIntFlag); // R11

endmodule

bind ctrl_endpoint ctrl_endpoint_chk #(.LEN_W(LEN_W)) uChk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busReset      (busReset),
  .tokValid      (tokValid),
  .tokKind       (tokKind),
  .dataLen       (dataLen),
  .hsValid       (hsValid),
  .hsCode        (hsCode),
  .epState       (epState),
  .pktRdy        (pktRdy),
  .dataEnd       (dataEnd),
  .sendStallPend (sendStallPend),
  .sentStall     (sentStall),
  .setupEnd      (setupEnd),
  .epIntFlag     (epIntFlag)
);

// File: tb/tb_ctrl_endpoint.sv
module tb_ctrl_endpoint;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_PKT    = 64;
  localparam int LEN_W      = $clog2(2 * MAX_PKT);

  localparam logic [6:0] F_CLRPKT   = 7'b0000001;
  localparam logic [6:0] F_DATAEND  = 7'b0000010;
  localparam logic [6:0] F_TXRDY    = 7'b0000100;
  localparam logic [6:0] F_STALL    = 7'b0001000;
  localparam logic [6:0] F_CLRSENT  = 7'b0010000;
  localparam logic [6:0] F_CLRSEND  = 7'b0100000;
  localparam logic [6:0] F_CLRINT   = 7'b1000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busReset = 1'b0;
  logic tokValid = 1'b0;
  logic [1:0] tokKind = 2'd0;
  logic [LEN_W-1:0] dataLen = '0;
  logic dataPid1 = 1'b0;
  logic setupDirIn = 1'b0;
  logic [15:0] setupLength = '0;
  logic fwClrPktRdy = 1'b0, fwDataEnd = 1'b0, fwTxReady = 1'b0, fwSendStall = 1'b0;
  logic fwClrSentStall = 1'b0, fwClrSetupEnd = 1'b0, fwClrInt = 1'b0;
  logic intMask = 1'b1, usbIntEn = 1'b1;
  logic hsValid, sentStall, setupEnd, epIntFlag, intReq, pktRdy, dataEnd, sendStallPend;
  logic [1:0] hsCode, epState;

  ctrl_endpoint #(.MAX_PKT(MAX_PKT)) dut (
    .clk(clk), .rst_n(rst_n), .busReset(busReset), .tokValid(tokValid),
    .tokKind(tokKind), .dataLen(dataLen), .dataPid1(dataPid1),
    .setupDirIn(setupDirIn), .setupLength(setupLength),
    .fwClrPktRdy(fwClrPktRdy), .fwDataEnd(fwDataEnd), .fwTxReady(fwTxReady),
    .fwSendStall(fwSendStall), .fwClrSentStall(fwClrSentStall),
    .fwClrSetupEnd(fwClrSetupEnd), .fwClrInt(fwClrInt),
    .intMask(intMask), .usbIntEn(usbIntEn),
    .hsValid(hsValid), .hsCode(hsCode), .epState(epState), .pktRdy(pktRdy),
    .dataEnd(dataEnd), .sendStallPend(sendStallPend), .sentStall(sentStall),
    .setupEnd(setupEnd), .epIntFlag(epIntFlag), .intReq(intReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";
  bit started = 0;
  bit wdFired = 0;

  // behavioural reference model
  int mState = 0;
  bit mPkt, mDataEnd, mSendStall, mSentStall, mSetupEnd, mTx, mInt, mDir, mHas;
  bit mHsValid;
  int mHsCode;
  int oSt;
  bit oPkt, oDE, oTx, oSS;

  task automatic hs(input int code);
    mHsValid = 1; mHsCode = code;
  endtask

  task automatic stallIt();
    hs(3); mSentStall = 1; mInt = 1; mDataEnd = 0; mTx = 0; mState = 0;
  endtask

  task automatic abortIt();
    mSetupEnd = 1; mInt = 1; mDataEnd = 0; mTx = 0; mState = 0;
  endtask

  always @(posedge clk) begin
    started <= 1'b1;
    mHsValid = 0; mHsCode = 0;
    if (!rst_n || busReset) begin
      mState = 0; mPkt = 0; mDataEnd = 0; mSendStall = 0; mSentStall = 0;
      mSetupEnd = 0; mTx = 0; mInt = 0; mDir = 0; mHas = 0;
    end else begin
      oSt = mState; oPkt = mPkt; oDE = mDataEnd; oTx = mTx; oSS = mSendStall;
      if (fwClrPktRdy) mPkt = 0;
      if (fwDataEnd) mDataEnd = 1;
      if (fwSendStall) mSendStall = 1;
      if (fwClrSentStall) mSentStall = 0;
      if (fwClrSetupEnd) mSetupEnd = 0;
      if (fwTxReady) mTx = 1;
      if (fwClrInt) mInt = 0;
      if (tokValid && tokKind != 2'd3) begin
        if (oSS) begin
          stallIt(); mSendStall = 0;
        end else if (tokKind == 2'd0) begin
          if (dataLen == 8) begin
            if (oSt != 0) abortIt();
            if (oPkt) hs(2);
            else begin
              hs(1); mPkt = 1; mInt = 1; mDataEnd = 0;
              mDir = setupDirIn; mHas = (setupLength != 0);
            end
          end
        end else if (tokKind == 2'd1) begin
          if (oSt == 0) begin
            if (oDE) begin hs(1); mDataEnd = 0; mInt = 1; end
            else hs(2);
          end else if (oSt == 1) begin
            if (oTx) begin hs(1); mTx = 0; mInt = 1; end
            else if (oDE) stallIt();
            else hs(2);
          end else begin
            if (oDE) begin hs(1); mDataEnd = 0; mInt = 1; mState = 0; end
            else abortIt();
          end
        end else begin
          if (oSt == 0) hs(2);
          else if (oSt == 1) begin
            if (oDE && !oTx) begin
              if (dataPid1 && dataLen == 0) begin hs(1); mDataEnd = 0; mInt = 1; mState = 0; end
              else stallIt();
            end else abortIt();
          end else begin
            if (oDE || dataLen > MAX_PKT) stallIt();
            else if (oPkt) hs(2);
            else begin hs(1); mPkt = 1; mInt = 1; end
          end
        end
      end else if (fwClrPktRdy && !fwDataEnd && oSt == 0 && oPkt && mHas) begin
        mState = mDir ? 1 : 2;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started && !wdFired) begin
      logic [11:0] expV, actV;
      expV = {mState[1:0], mHsValid, mHsCode[1:0], mPkt, mDataEnd, mSendStall,
              mSentStall, mSetupEnd, mInt, (mInt && intMask && usbIntEn)};
      actV = {epState, hsValid, hsCode, pktRdy, dataEnd, sendStallPend,
              sentStall, setupEnd, epIntFlag, intReq};
      checks++;
      if (actV !== expV) begin
        fails++;
        $display("FAIL %s at %0t: actual=%b expected=%b", curReq, $time, actV, expV);
      end
    end
  end

  task automatic sendTok(input logic [1:0] k, input int len, input logic pid1);
    tokValid = 1; tokKind = k; dataLen = LEN_W'(len); dataPid1 = pid1;
    @(posedge clk); #2;
    tokValid = 0; tokKind = 0; dataLen = '0; dataPid1 = 0;
    @(posedge clk); #2;
  endtask

  task automatic setupTok(input logic dirIn, input int reqLen);
    setupDirIn = dirIn; setupLength = 16'(reqLen);
    sendTok(2'd0, 8, 1'b0);
  endtask

  task automatic fw(input logic [6:0] m);
    {fwClrInt, fwClrSetupEnd, fwClrSentStall, fwSendStall, fwTxReady, fwDataEnd, fwClrPktRdy} = m;
    @(posedge clk); #2;
    {fwClrInt, fwClrSetupEnd, fwClrSentStall, fwSendStall, fwTxReady, fwDataEnd, fwClrPktRdy} = '0;
    @(posedge clk); #2;
  endtask

  task automatic runTests();
    curReq = "R1";
    repeat (3) @(posedge clk);
    #2; rst_n = 1;
    @(posedge clk); #2;

    curReq = "R2";
    sendTok(2'd0, 7, 1'b0);      // wrong setup length: silent
    sendTok(2'd3, 8, 1'b0);      // reserved kind: ignored
    setupTok(1'b1, 16);          // accepted
    curReq = "R3";
    setupTok(1'b1, 16);          // NAK while packet-ready
    curReq = "R4";
    fw(F_CLRPKT | F_CLRINT);     // to transmit
    curReq = "R5";
    sendTok(2'd1, 0, 1'b0);      // NAK, nothing loaded
    fw(F_TXRDY);
    sendTok(2'd1, 0, 1'b0);      // ACK
    fw(F_TXRDY | F_DATAEND);
    sendTok(2'd1, 0, 1'b0);      // ACK last
    curReq = "R6";
    sendTok(2'd1, 0, 1'b0);      // extra IN: STALL
    fw(F_CLRSENT | F_CLRINT);

    curReq = "R8";
    setupTok(1'b1, 4);
    fw(F_CLRPKT);
    fw(F_TXRDY | F_DATAEND);
    sendTok(2'd1, 0, 1'b0);
    sendTok(2'd2, 0, 1'b1);      // good status: ACK
    setupTok(1'b1, 4);
    fw(F_CLRPKT);
    fw(F_TXRDY | F_DATAEND);
    sendTok(2'd1, 0, 1'b0);
    sendTok(2'd2, 3, 1'b1);      // nonzero status: STALL
    fw(F_CLRSENT);
    setupTok(1'b1, 4);
    fw(F_CLRPKT);
    fw(F_TXRDY | F_DATAEND);
    sendTok(2'd1, 0, 1'b0);
    sendTok(2'd2, 0, 1'b0);      // DATA0 status: STALL
    fw(F_CLRSENT | F_CLRINT);

    curReq = "R7";
    setupTok(1'b0, 8);
    fw(F_CLRPKT);                // to receive
    sendTok(2'd2, 70, 1'b1);     // oversized: STALL
    fw(F_CLRSENT);
    setupTok(1'b0, 8);
    fw(F_CLRPKT);
    sendTok(2'd2, 64, 1'b1);     // max size: ACK
    curReq = "R3";
    sendTok(2'd2, 8, 1'b0);      // NAK, packet pending
    curReq = "R7";
    fw(F_CLRPKT | F_DATAEND);
    sendTok(2'd2, 8, 1'b0);      // after data-end: STALL
    fw(F_CLRSENT | F_CLRINT);

    curReq = "R8";
    setupTok(1'b0, 8);
    fw(F_CLRPKT);
    sendTok(2'd2, 8, 1'b1);
    fw(F_CLRPKT | F_DATAEND);
    sendTok(2'd1, 0, 1'b0);      // IN status: ACK
    curReq = "R4";
    setupTok(1'b0, 0);
    fw(F_CLRPKT | F_DATAEND);    // no data stage: stays idle
    curReq = "R8";
    sendTok(2'd1, 0, 1'b0);
    sendTok(2'd1, 0, 1'b0);      // nothing pending: NAK

    curReq = "R9";
    setupTok(1'b1, 8);
    fw(F_CLRPKT);
    sendTok(2'd2, 0, 1'b1);      // early OUT: setup-end
    fw(F_CLRSEND | F_CLRINT);
    setupTok(1'b0, 8);
    fw(F_CLRPKT);
    sendTok(2'd1, 0, 1'b0);      // early IN: setup-end
    fw(F_CLRSEND);
    setupTok(1'b0, 8);
    fw(F_CLRPKT);
    setupTok(1'b1, 2);           // setup inside data stage
    fw(F_CLRSEND | F_CLRPKT | F_DATAEND);
    sendTok(2'd1, 0, 1'b0);

    curReq = "R10";
    fw(F_STALL);
    sendTok(2'd1, 0, 1'b0);      // idle: STALL
    sendTok(2'd1, 0, 1'b0);      // stall-sent held, normal NAK
    fw(F_CLRSENT);
    setupTok(1'b0, 8);
    fw(F_CLRPKT);
    fw(F_STALL);
    sendTok(2'd2, 4, 1'b0);      // receive: STALL
    fw(F_CLRSENT | F_CLRINT);

    curReq = "R11";
    setupTok(1'b0, 0);
    intMask = 0; @(posedge clk); #2;
    usbIntEn = 0; @(posedge clk); #2;
    intMask = 1; @(posedge clk); #2;
    usbIntEn = 1; @(posedge clk); #2;
    fw(F_CLRINT);
    fw(F_CLRPKT | F_DATAEND);
    sendTok(2'd1, 0, 1'b0);

    curReq = "R1";
    setupTok(1'b0, 8);
    fw(F_CLRPKT | F_STALL);
    busReset = 1; @(posedge clk); #2;
    busReset = 0; @(posedge clk); #2;
    sendTok(2'd2, 4, 1'b0);      // after bus reset: idle NAK
    repeat (2) @(posedge clk);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (20000) @(posedge clk);
        wdFired = 1;
      end
    join_any
    disable fork;
    if (wdFired) begin
      checks++; fails++;
      $display("FAIL %s watchdog: actual=expired expected=finished", curReq);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule